// File: doc/BRIEF.md
# Watchdog Timer with Selectable Prescaler

This block guards a processor against runaway software. It counts ticks from one of three sources chosen by configuration: a slow free-running oscillator tick, a real-time-clock tick, or the instruction-rate tick (one quarter of the system clock). The oscillators are outside the block and arrive as single-cycle enable pulses on the block clock. Every count passes through a fixed divide-by-256 stage and then a 7-bit prescaler. A 3-bit field in an 8-bit option register picks one of eight prescaler taps as the time-out point.

When the selected count runs out, the block raises a one-cycle request. If the processor is running, the request is a full chip reset. If the processor is in halt, the request is a warm reset that restarts only the program counter and the stack pointer. The block also owns two status flags that software reads after a reset. The time-out flag records that the watchdog fired. The power-down flag records that a halt instruction was executed.

Software keeps the timer alive with clear instructions. In single-clear mode one instruction is enough. In paired mode two distinct clear instructions must both be seen, in either order.

Top module: `wdog_timer`

## Requirements
- R1: After reset, to_flag, pd_flag, chip_reset_req and warm_reset_req are 0, opt_rdata is 8'h00, and the count is zero.
- R2: A time-out occurs on the tick that completes 256 × 2^s counted ticks, where s is opt_rdata[2:0] (0 gives 256 ticks, 7 gives 32768 ticks). It is reported one cycle after that tick, and the count then restarts from zero.
- R3: cfg_src selects the counted tick: 0 = tick_slow, 1 = tick_rtc, 2 = tick_instr, 3 = none. Ticks on the sources that are not selected are ignored.
- R4: A time-out while halted is 0 gives a single-cycle chip_reset_req. A time-out while halted is 1 gives a single-cycle warm_reset_req. The two requests are never high together.
- R5: Every time-out sets to_flag.
- R6: With cfg_dual_clear = 0, op_clr clears the count, to_flag and pd_flag. In this mode op_clr_a and op_clr_b have no effect.
- R7: With cfg_dual_clear = 1, the count and both flags are cleared only once op_clr_a and op_clr_b have both been seen, in either order. In this mode op_clr has no effect.
- R8: op_halt clears the count and to_flag, sets pd_flag, and discards a half-completed clear pair.
- R9: When cfg_src = 2 and halted = 1, no ticks are counted.
- R10: With cfg_enable = 0 nothing is counted, no time-out occurs, and op_clr, op_clr_a, op_clr_b and op_halt leave the count and both flags unchanged.
- R11: opt_we writes opt_wdata into the option register, which reads back on opt_rdata from the next cycle. Bits 3 and 7:4 are stored but do not change the timing.
- R12: Within one cycle, op_halt takes precedence over a clear, and a clear takes precedence over a tick that would otherwise time out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Power-up / external reset, active low |
| cfg_enable | input | 1 | Watchdog enabled by configuration |
| cfg_src | input | 2 | Tick source select |
| cfg_dual_clear | input | 1 | Paired clear mode |
| tick_slow | input | 1 | Slow oscillator tick |
| tick_rtc | input | 1 | Real-time-clock tick |
| tick_instr | input | 1 | Instruction-rate tick |
| halted | input | 1 | Processor is in halt |
| op_clr | input | 1 | Single clear instruction executed |
| op_clr_a | input | 1 | First paired clear instruction executed |
| op_clr_b | input | 1 | Second paired clear instruction executed |
| op_halt | input | 1 | Halt instruction executed |
| opt_we | input | 1 | Option register write strobe |
| opt_wdata | input | 8 | Option register write data |
| opt_rdata | output | 8 | Option register contents |
| to_flag | output | 1 | Time-out status flag |
| pd_flag | output | 1 | Power-down status flag |
| chip_reset_req | output | 1 | Full reset request pulse |
| warm_reset_req | output | 1 | Warm reset request pulse |

## Verification
The hidden count is visible only through the moment a reset request appears. An error in the divider, in the prescaler or in a clear path therefore shows as a request that arrives early, arrives late, or never arrives. At the longest tap this can be up to 32768 ticks after the fault. A wrong pair-tracking state shows at the next paired clear, either as a clear that does not happen or as one that happens too soon, and the following time-out moves by the same amount. The bench's cycle-level reference model compares every output on every clock, so a wrong flag or a wrong request type is reported on the cycle it first differs.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  // Counted tick source as encoded on cfg_src
  typedef enum logic [1:0] {
    SRC_SLOW  = 2'd0,
    SRC_RTC   = 2'd1,
    SRC_INSTR = 2'd2,
    SRC_NONE  = 2'd3
  } wdog_src_e;

endpackage

// File: rtl/wdog_stage.sv
// Fixed first divider stage: counts accepted ticks and flags when it is full.
module wdog_stage #(
  parameter int unsigned W = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  output logic full
);

  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)      cnt_d = '0;
    else if (inc) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign full = &cnt_q;

endmodule

// File: rtl/wdog_prescale.sv
// Prescaler after the fixed stage; sel picks how many of its low bits must be
// all ones before a time-out (tap 0 means no extra division).
module wdog_prescale #(
  parameter int unsigned PRE_W = 7,
  parameter int unsigned SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  input  logic [SEL_W-1:0] sel,
  output logic             tap_full
);

  logic [PRE_W-1:0] cnt_q, cnt_d;
  logic [PRE_W:0]   taps;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)      cnt_d = '0;
    else if (inc) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign taps[0] = 1'b1;
  for (genvar k = 1; k <= PRE_W; k++) begin : g_tap
    assign taps[k] = &cnt_q[k-1:0];
  end

  assign tap_full = taps[sel];

endmodule

// File: rtl/wdog_flags.sv
// Clear-instruction decoding (single or paired) and the two status flags.
module wdog_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic dual,
  input  logic op_clr,
  input  logic op_clr_a,
  input  logic op_clr_b,
  input  logic halt_evt,
  input  logic timeout,
  output logic clr_evt,
  output logic to_flag,
  output logic pd_flag
);

  logic seen_a_q, seen_a_d;
  logic seen_b_q, seen_b_d;
  logic to_q, to_d;
  logic pd_q, pd_d;
  logic pair_done;

  assign pair_done = (op_clr_a && (op_clr_b || seen_b_q)) ||
                     (op_clr_b && (op_clr_a || seen_a_q));
  assign clr_evt   = en && !halt_evt && (dual ? pair_done : op_clr);

  always_comb begin
    seen_a_d = seen_a_q;
    seen_b_d = seen_b_q;
    to_d     = to_q;
    pd_d     = pd_q;
    if (halt_evt) begin
      seen_a_d = 1'b0;
      seen_b_d = 1'b0;
      to_d     = 1'b0;
      pd_d     = 1'b1;
    end else if (clr_evt) begin
      seen_a_d = 1'b0;
      seen_b_d = 1'b0;
      to_d     = 1'b0;
      pd_d     = 1'b0;
    end else begin
      if (en && dual) begin
        seen_a_d = seen_a_q || op_clr_a;
        seen_b_d = seen_b_q || op_clr_b;
      end
      if (timeout) to_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_a_q <= 1'b0;
      seen_b_q <= 1'b0;
      to_q     <= 1'b0;
      pd_q     <= 1'b0;
    end else begin
      seen_a_q <= seen_a_d;
      seen_b_q <= seen_b_d;
      to_q     <= to_d;
      pd_q     <= pd_d;
    end
  end

  assign to_flag = to_q;
  assign pd_flag = pd_q;

endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
  import wdog_pkg::*;
#(
  parameter int unsigned BASE_W = 8,
  parameter int unsigned PRE_W  = 7,
  parameter int unsigned OPT_W  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_enable,
  input  logic [1:0]       cfg_src,
  input  logic             cfg_dual_clear,
  input  logic             tick_slow,
  input  logic             tick_rtc,
  input  logic             tick_instr,
  input  logic             halted,
  input  logic             op_clr,
  input  logic             op_clr_a,
  input  logic             op_clr_b,
  input  logic             op_halt,
  input  logic             opt_we,
  input  logic [OPT_W-1:0] opt_wdata,
  output logic [OPT_W-1:0] opt_rdata,
  output logic             to_flag,
  output logic             pd_flag,
  output logic             chip_reset_req,
  output logic             warm_reset_req
);

  localparam int unsigned SEL_W = $clog2(PRE_W + 1);

  // Reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe_q;
  logic       rst_q_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_q_n = rst_pipe_q[1];

  // Option register
  logic [OPT_W-1:0] opt_q, opt_d;

  always_comb begin
    opt_d = opt_q;
    if (opt_we) opt_d = opt_wdata;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) opt_q <= '0;
    else          opt_q <= opt_d;
  end
  assign opt_rdata = opt_q;

  // Tick source selection
  wdog_src_e src;
  logic      src_tick;
  logic      count_en;

  assign src = wdog_src_e'(cfg_src);

  always_comb begin
    unique case (src)
      SRC_SLOW:  src_tick = tick_slow;
      SRC_RTC:   src_tick = tick_rtc;
      SRC_INSTR: src_tick = tick_instr;
      default:   src_tick = 1'b0;
    endcase
  end

  assign count_en = cfg_enable && src_tick && !(halted && (src == SRC_INSTR));

  // Events
  logic halt_evt, clr_evt, timeout, cnt_clr;
  logic base_full, tap_full;

  assign halt_evt = cfg_enable && op_halt;
  assign timeout  = count_en && base_full && tap_full && !halt_evt && !clr_evt;
  assign cnt_clr  = halt_evt || clr_evt || timeout;

  wdog_stage #(.W(BASE_W)) u_stage (
    .clk   (clk),
    .rst_n (rst_q_n),
    .clr   (cnt_clr),
    .inc   (count_en),
    .full  (base_full)
  );

  wdog_prescale #(.PRE_W(PRE_W), .SEL_W(SEL_W)) u_pre (
    .clk      (clk),
    .rst_n    (rst_q_n),
    .clr      (cnt_clr),
    .inc      (count_en && base_full),
    .sel      (opt_q[SEL_W-1:0]),
    .tap_full (tap_full)
  );

  wdog_flags u_flags (
    .clk      (clk),
    .rst_n    (rst_q_n),
    .en       (cfg_enable),
    .dual     (cfg_dual_clear),
    .op_clr   (op_clr),
    .op_clr_a (op_clr_a),
    .op_clr_b (op_clr_b),
    .halt_evt (halt_evt),
    .timeout  (timeout),
    .clr_evt  (clr_evt),
    .to_flag  (to_flag),
    .pd_flag  (pd_flag)
  );

  // Reset request pulses
  logic chip_q, chip_d, warm_q, warm_d;

  always_comb begin
    chip_d = timeout && !halted;
    warm_d = timeout && halted;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      chip_q <= 1'b0;
      warm_q <= 1'b0;
    end else begin
      chip_q <= chip_d;
      warm_q <= warm_d;
    end
  end

  assign chip_reset_req = chip_q;
  assign warm_reset_req = warm_q;

endmodule

// File: rtl/wdog_timer_chk.sv
module wdog_timer_chk #(
  parameter int unsigned OPT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_enable,
  input logic             cfg_dual_clear,
  input logic             halted,
  input logic             op_clr,
  input logic             op_halt,
  input logic             opt_we,
  input logic [OPT_W-1:0] opt_rdata,
  input logic             to_flag,
  input logic             pd_flag,
  input logic             chip_reset_req,
  input logic             warm_reset_req
);

  assert_req_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({chip_reset_req, warm_reset_req}));

  assert_chip_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    chip_reset_req |=> !chip_reset_req);

  assert_warm_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    warm_reset_req |=> !warm_reset_req);

  assert_warm_only_halted_R4: assert property (@(posedge clk) disable iff (!rst_n)
    warm_reset_req |-> $past(halted));

  assert_chip_only_running_R4: assert property (@(posedge clk) disable iff (!rst_n)
    chip_reset_req |-> !$past(halted));

  assert_to_on_timeout_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (chip_reset_req || warm_reset_req) |-> to_flag);

  assert_single_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_enable && !cfg_dual_clear && op_clr && !op_halt) |=> (!to_flag && !pd_flag));

  assert_halt_flags_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_enable && op_halt) |=> (pd_flag && !to_flag));

  assert_disabled_no_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_enable |=> (!chip_reset_req && !warm_reset_req));

  assert_disabled_flags_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_enable |=> ($stable(to_flag) && $stable(pd_flag)));

  assert_opt_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !opt_we |=> $stable(opt_rdata));

endmodule

bind wdog_timer wdog_timer_chk #(.OPT_W(OPT_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_q_n),
  .cfg_enable     (cfg_enable),
  .cfg_dual_clear (cfg_dual_clear),
  .halted         (halted),
  .op_clr         (op_clr),
  .op_halt        (op_halt),
  .opt_we         (opt_we),
  .opt_rdata      (opt_rdata),
  .to_flag        (to_flag),
  .pd_flag        (pd_flag),
  .chip_reset_req (chip_reset_req),
  .warm_reset_req (warm_reset_req)
);

// File: tb/wdog_timer_tb.sv
module wdog_timer_tb;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 190000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_enable = 1'b0;
  logic [1:0] cfg_src = 2'd0;
  logic       cfg_dual_clear = 1'b0;
  logic       tick_slow = 1'b0, tick_rtc = 1'b0, tick_instr = 1'b0;
  logic       halted = 1'b0;
  logic       op_clr = 1'b0, op_clr_a = 1'b0, op_clr_b = 1'b0, op_halt = 1'b0;
  logic       opt_we = 1'b0;
  logic [7:0] opt_wdata = 8'h00;
  logic [7:0] opt_rdata;
  logic       to_flag, pd_flag, chip_reset_req, warm_reset_req;

  int    checks = 0;
  int    errors = 0;
  bit    done = 1'b0;
  string cur_req = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  wdog_timer u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_src(cfg_src),
    .cfg_dual_clear(cfg_dual_clear), .tick_slow(tick_slow), .tick_rtc(tick_rtc),
    .tick_instr(tick_instr), .halted(halted), .op_clr(op_clr), .op_clr_a(op_clr_a),
    .op_clr_b(op_clr_b), .op_halt(op_halt), .opt_we(opt_we), .opt_wdata(opt_wdata),
    .opt_rdata(opt_rdata), .to_flag(to_flag), .pd_flag(pd_flag),
    .chip_reset_req(chip_reset_req), .warm_reset_req(warm_reset_req)
  );

  // Behavioural reference model
  int       m_cnt;
  bit       m_to, m_pd, m_chip, m_warm, m_sa, m_sb;
  bit [7:0] m_opt;
  bit       m_tick, m_clr, m_pair;
  int       m_limit;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_to = 0; m_pd = 0; m_chip = 0; m_warm = 0;
      m_sa = 0; m_sb = 0; m_opt = 8'h00;
    end else begin
      m_chip = 0;
      m_warm = 0;
      if (cfg_enable) begin
        case (cfg_src)
          2'd0:    m_tick = tick_slow;
          2'd1:    m_tick = tick_rtc;
          2'd2:    m_tick = tick_instr && !halted;
          default: m_tick = 0;
        endcase
        m_pair  = (op_clr_a && (op_clr_b || m_sb)) || (op_clr_b && (op_clr_a || m_sa));
        m_clr   = cfg_dual_clear ? m_pair : op_clr;
        m_limit = 256 << m_opt[2:0];
        if (op_halt) begin
          m_cnt = 0; m_to = 0; m_pd = 1; m_sa = 0; m_sb = 0;
        end else if (m_clr) begin
          m_cnt = 0; m_to = 0; m_pd = 0; m_sa = 0; m_sb = 0;
        end else begin
          if (cfg_dual_clear) begin
            m_sa = m_sa || op_clr_a;
            m_sb = m_sb || op_clr_b;
          end
          if (m_tick) begin
            if (m_cnt + 1 == m_limit) begin
              m_cnt = 0;
              m_to  = 1;
              if (halted) m_warm = 1; else m_chip = 1;
            end else begin
              m_cnt = m_cnt + 1;
            end
          end
        end
      end
      if (opt_we) m_opt = opt_wdata;
    end
  end

  // Per-clock comparison and pulse counting
  int n_chip = 0, n_warm = 0;

  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (to_flag !== m_to || pd_flag !== m_pd || chip_reset_req !== m_chip ||
          warm_reset_req !== m_warm || opt_rdata !== m_opt) begin
        errors++;
        $display("FAIL %s per-clock: act to=%b pd=%b chip=%b warm=%b opt=%h exp to=%b pd=%b chip=%b warm=%b opt=%h",
                 cur_req, to_flag, pd_flag, chip_reset_req, warm_reset_req, opt_rdata,
                 m_to, m_pd, m_chip, m_warm, m_opt);
      end
      if (chip_reset_req === 1'b1) n_chip++;
      if (warm_reset_req === 1'b1) n_warm++;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Drive ticks (bit0 slow, bit1 rtc, bit2 instr) and ops (bit0 clr, bit1 a,
  // bit2 b, bit3 halt) for n cycles
  task automatic drive(input int n, input bit [2:0] tk, input bit [3:0] ops);
    @(negedge clk);
    {tick_instr, tick_rtc, tick_slow} = tk;
    {op_halt, op_clr_b, op_clr_a, op_clr} = ops;
    repeat (n) @(negedge clk);
    {tick_instr, tick_rtc, tick_slow} = 3'b000;
    {op_halt, op_clr_b, op_clr_a, op_clr} = 4'b0000;
  endtask

  task automatic wopt(input logic [7:0] v);
    @(negedge clk);
    opt_we = 1'b1; opt_wdata = v;
    @(negedge clk);
    opt_we = 1'b0;
  endtask

  int base_chip = 0, base_warm = 0;

  task automatic pulses(input string req, input int exp_chip, input int exp_warm);
    repeat (2) @(negedge clk);
    check(n_chip - base_chip == exp_chip, req, "chip_reset_req pulses", n_chip - base_chip, exp_chip);
    check(n_warm - base_warm == exp_warm, req, "warm_reset_req pulses", n_warm - base_warm, exp_warm);
    base_chip = n_chip;
    base_warm = n_warm;
  endtask

  task automatic flags(input string req, input bit exp_to, input bit exp_pd);
    @(negedge clk);
    check(to_flag === exp_to, req, "to_flag", int'(to_flag), int'(exp_to));
    check(pd_flag === exp_pd, req, "pd_flag", int'(pd_flag), int'(exp_pd));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1: reset state
    cur_req = "R1";
    check(opt_rdata === 8'h00, "R1", "opt_rdata", int'(opt_rdata), 0);
    check(chip_reset_req === 1'b0 && warm_reset_req === 1'b0, "R1", "requests",
          int'({chip_reset_req, warm_reset_req}), 0);
    flags("R1", 0, 0);
    cfg_enable = 1'b1;

    // R11: user bits stored, no effect on timing
    cur_req = "R11";
    wopt(8'hF8);
    check(opt_rdata === 8'hF8, "R11", "opt_rdata", int'(opt_rdata), 8'hF8);
    drive(255, 3'b001, 4'b0000);
    pulses("R11", 0, 0);
    drive(1, 3'b001, 4'b0000);
    pulses("R11", 1, 0);
    flags("R5", 1, 0);

    // R2: longer taps
    cur_req = "R2";
    wopt(8'h03);
    drive(1, 3'b000, 4'b0001);
    drive(2047, 3'b001, 4'b0000);
    pulses("R2", 0, 0);
    drive(1, 3'b001, 4'b0000);
    pulses("R2", 1, 0);
    wopt(8'h07);
    drive(32767, 3'b001, 4'b0000);
    pulses("R2", 0, 0);
    drive(1, 3'b001, 4'b0000);
    pulses("R2", 1, 0);
    wopt(8'h00);

    // R3: source select
    cur_req = "R3";
    cfg_src = 2'd1;
    drive(600, 3'b101, 4'b0000);
    pulses("R3", 0, 0);
    drive(256, 3'b010, 4'b0000);
    pulses("R3", 1, 0);
    cfg_src = 2'd3;
    drive(600, 3'b111, 4'b0000);
    pulses("R3", 0, 0);

    // R9: instruction tick frozen in halt
    cur_req = "R9";
    cfg_src = 2'd2;
    halted  = 1'b1;
    drive(600, 3'b100, 4'b0000);
    pulses("R9", 0, 0);
    halted = 1'b0;
    drive(256, 3'b100, 4'b0000);
    pulses("R9", 1, 0);

    // R4: warm reset in halt
    cur_req = "R4";
    cfg_src = 2'd0;
    halted  = 1'b1;
    drive(256, 3'b001, 4'b0000);
    pulses("R4", 0, 1);
    halted = 1'b0;
    flags("R5", 1, 0);

    // R6: single clear mode
    cur_req = "R6";
    drive(1, 3'b000, 4'b0001);
    flags("R6", 0, 0);
    drive(200, 3'b001, 4'b0000);
    drive(1, 3'b000, 4'b0010);
    drive(1, 3'b000, 4'b0100);
    drive(56, 3'b001, 4'b0000);
    pulses("R6", 1, 0);
    drive(200, 3'b001, 4'b0000);
    drive(1, 3'b000, 4'b0001);
    drive(255, 3'b001, 4'b0000);
    pulses("R6", 0, 0);
    drive(1, 3'b001, 4'b0000);
    pulses("R6", 1, 0);

    // R7: paired clear mode
    cur_req = "R7";
    cfg_dual_clear = 1'b1;
    drive(100, 3'b001, 4'b0000);
    drive(1, 3'b000, 4'b0001);
    drive(100, 3'b001, 4'b0000);
    drive(1, 3'b000, 4'b0010);
    drive(56, 3'b001, 4'b0000);
    pulses("R7", 1, 0);
    drive(100, 3'b001, 4'b0000);
    drive(1, 3'b000, 4'b0100);
    flags("R7", 0, 0);
    drive(255, 3'b001, 4'b0000);
    pulses("R7", 0, 0);
    drive(1, 3'b001, 4'b0000);
    pulses("R7", 1, 0);
    drive(100, 3'b001, 4'b0000);
    drive(1, 3'b000, 4'b0100);
    drive(50, 3'b001, 4'b0000);
    drive(1, 3'b000, 4'b0010);
    drive(255, 3'b001, 4'b0000);
    pulses("R7", 0, 0);
    drive(1, 3'b001, 4'b0000);
    pulses("R7", 1, 0);

    // R8: halt instruction
    cur_req = "R8";
    drive(100, 3'b001, 4'b0000);
    drive(1, 3'b000, 4'b0010);
    drive(1, 3'b000, 4'b1000);
    flags("R8", 0, 1);
    drive(100, 3'b001, 4'b0000);
    drive(1, 3'b000, 4'b0100);
    drive(155, 3'b001, 4'b0000);
    pulses("R8", 0, 0);
    drive(1, 3'b001, 4'b0000);
    pulses("R8", 1, 0);
    flags("R8", 1, 1);
    drive(1, 3'b000, 4'b0010);
    flags("R7", 0, 0);
    cfg_dual_clear = 1'b0;

    // R10: disabled
    cur_req = "R10";
    cfg_enable = 1'b0;
    drive(600, 3'b111, 4'b0000);
    pulses("R10", 0, 0);
    drive(1, 3'b000, 4'b1000);
    flags("R10", 0, 0);
    cfg_enable = 1'b1;
    drive(256, 3'b001, 4'b0000);
    pulses("R10", 1, 0);
    cfg_enable = 1'b0;
    drive(1, 3'b000, 4'b0001);
    flags("R10", 1, 0);
    cfg_enable = 1'b1;

    // R12: same-cycle priorities
    cur_req = "R12";
    drive(1, 3'b000, 4'b1001);
    flags("R12", 0, 1);
    drive(1, 3'b000, 4'b0001);
    drive(255, 3'b001, 4'b0000);
    drive(1, 3'b001, 4'b0001);
    pulses("R12", 0, 0);
    drive(255, 3'b001, 4'b0000);
    pulses("R12", 0, 0);
    drive(1, 3'b001, 4'b0000);
    pulses("R12", 1, 0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule